// File: doc/BRIEF.md
# Adaptive Chopper Blanking Timer

This block sits between the current-trip comparator and the PWM chopper of one motor winding. Each time a drive on-period begins, it starts a blanking window. While the window runs, every trip-input transition is suppressed. The window therefore also sets the shortest on-time the chopper can produce. When automatic decay control switches the bridge into fast decay, the same window starts again.

The window length comes from a programmed count. When the adaptive mode is enabled and the commanded current-step magnitude is below 30% of full scale, the window is half that count. The length is taken when the window starts and stays fixed until the window ends. Outside the window, a trip on the comparator input produces one single-cycle qualified pulse for the chopper.

Top module: `chop_blank_timer`

## Requirements
- R1: A start strobe sampled at a clock edge sets `blank_o` high for exactly L cycles after that edge, where L is the window length chosen at that edge.
- R2: `trip_o` never rises in the cycle that follows a cycle in which `blank_o` or an accepted start strobe was high. A trip seen during the window does not shorten the window.
- R3: When `auto_decay_i` is 1, a `fast_start_i` strobe starts a window exactly as `on_start_i` does.
- R4: L equals `blank_cnt_i` shifted right by one (floor of half) when `adapt_en_i` is 1 and `step_mag_i`*10 < FULL_SCALE*3. Otherwise L equals `blank_cnt_i`. With the default FULL_SCALE of 255, a step of 76 halves the window and a step of 77 does not.
- R5: When `auto_decay_i` is 0, `fast_start_i` has no effect on `blank_o` or `trip_o`.
- R6: Changes to `step_mag_i`, `adapt_en_i` or `blank_cnt_i` during a running window do not change when that window ends.
- R7: A start strobe accepted during a running window restarts it with a full new length L counted from that strobe.
- R8: After the window, `trip_o` pulses high for one cycle, one cycle after the first unmasked cycle in which `trip_raw_i` is high. It pulses again only after `trip_raw_i` falls and rises, or after a new window ends.
- R9: During and directly after reset, `blank_o` and `trip_o` are 0.
- R10: A window length of zero produces no blanking. Only the strobe cycle itself is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_start_i | input | 1 | Strobe: drive on-period begins |
| fast_start_i | input | 1 | Strobe: fast decay entered |
| auto_decay_i | input | 1 | Automatic decay control is active |
| trip_raw_i | input | 1 | Raw current-trip comparator output |
| blank_cnt_i | input | CNT_W | Programmed blanking length in clock cycles |
| adapt_en_i | input | 1 | Enable for halving at low current steps |
| step_mag_i | input | STEP_W | Unsigned commanded current-step magnitude |
| trip_o | output | 1 | Single-cycle qualified trip pulse |
| blank_o | output | 1 | Blanking window active |

## Verification
On every cycle, the assertions check the following:
- a trip pulse never follows a masked cycle;
- a pulse lasts exactly one cycle;
- the window counter loads the length it was given and counts down by one;
- a strobe at a low step with the adaptive mode enabled yields the halved length;
- a fast-decay strobe with automatic decay off starts nothing.

Only the bench scenarios can show the following:
- the end-to-end timing of a window;
- that a length stays latched when inputs change mid-window;
- a restart mid-window;
- the exact 76/77 step boundary;
- a zero length;
- a re-trip after the comparator falls and rises again.

// File: rtl/chop_blank_pkg.sv
package chop_blank_pkg;

    typedef struct packed {
        logic trip;
        logic held;
    } qual_state_t;

    function automatic logic below_thirty_pct(input int unsigned mag,
                                              input int unsigned full_scale);
        return (mag * 10) < (full_scale * 3);
    endfunction

endpackage

// File: rtl/chop_step_level.sv
module chop_step_level #(
    parameter int STEP_W     = 8,
    parameter int FULL_SCALE = 255
) (
    input  logic [STEP_W-1:0] step_mag_i,
    output logic              low_o
);
    import chop_blank_pkg::*;

    localparam int PAD_W = 32 - STEP_W;

    always_comb begin
        low_o = below_thirty_pct({{PAD_W{1'b0}}, step_mag_i}, FULL_SCALE);
    end

endmodule

// File: rtl/chop_blank_window.sv
module chop_blank_window #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             active_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] rem;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.rem = len_i;
        end else if (st_q.rem != '0) begin
            st_d.rem = st_q.rem - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.rem != '0);

    // R1 / R7: a strobe loads the full requested length
    p_load_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.rem == $past(len_i)));

    // R1: without a strobe the window shrinks by exactly one per cycle
    p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.rem != '0) |=> (st_q.rem == $past(st_q.rem) - ONE));

endmodule

// File: rtl/chop_trip_qual.sv
module chop_trip_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_i,
    input  logic trip_raw_i,
    output logic trip_o
);
    import chop_blank_pkg::*;

    qual_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trip = !mask_i && trip_raw_i && !st_q.held;
        st_d.held = !mask_i && trip_raw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trip_o = st_q.trip;

    // R8: the qualified trip lasts one cycle
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |=> !trip_o);

endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
    parameter int CNT_W      = 8,
    parameter int STEP_W     = 8,
    parameter int FULL_SCALE = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_start_i,
    input  logic              fast_start_i,
    input  logic              auto_decay_i,
    input  logic              trip_raw_i,
    input  logic [CNT_W-1:0]  blank_cnt_i,
    input  logic              adapt_en_i,
    input  logic [STEP_W-1:0] step_mag_i,
    output logic              trip_o,
    output logic              blank_o
);
    logic             low_step;
    logic             strobe;
    logic             mask;
    logic [CNT_W-1:0] len_sel;

    chop_step_level #(
        .STEP_W     (STEP_W),
        .FULL_SCALE (FULL_SCALE)
    ) i_level (
        .step_mag_i (step_mag_i),
        .low_o      (low_step)
    );

    always_comb begin
        strobe  = on_start_i || (fast_start_i && auto_decay_i);
        len_sel = (adapt_en_i && low_step) ? (blank_cnt_i >> 1) : blank_cnt_i;
        mask    = blank_o || strobe;
    end

    chop_blank_window #(
        .CNT_W (CNT_W)
    ) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (strobe),
        .len_i    (len_sel),
        .active_o (blank_o)
    );

    chop_trip_qual i_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_i     (mask),
        .trip_raw_i (trip_raw_i),
        .trip_o     (trip_o)
    );

    // R2: no qualified trip after a masked cycle
    p_trip_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_o || on_start_i || (fast_start_i && auto_decay_i)) |=> !trip_o);

    // R4: an adaptive strobe at a low step gives a halved window
    p_halved_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (on_start_i && adapt_en_i && low_step)
            |=> (blank_o == ($past(blank_cnt_i >> 1) != '0)));

    // R5: a fast-decay strobe without automatic decay starts nothing
    p_fast_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_start_i && !auto_decay_i && !on_start_i && !blank_o) |=> !blank_o);

endmodule

// File: tb/test_chop_blank_timer.sv
module test_chop_blank_timer;
    localparam int CNT_W = 8;
    localparam int STEP_W = 8;
    localparam int FS = 255;

    logic clk = 0;
    logic rst_n = 0;
    logic on_s = 0, fast_s = 0, auto_d = 0, trip = 0, adapt = 0;
    logic [CNT_W-1:0] bcnt = 0;
    logic [STEP_W-1:0] step = 0;
    logic trip_o, blank_o;

    int checks = 0;
    int fails = 0;
    string req = "R9";

    // reference state
    int rem = 0;
    bit held = 0;
    bit texp = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    chop_blank_timer #(.CNT_W(CNT_W), .STEP_W(STEP_W), .FULL_SCALE(FS)) i_chop_blank_timer (
        .clk(clk), .rst_n(rst_n), .on_start_i(on_s), .fast_start_i(fast_s),
        .auto_decay_i(auto_d), .trip_raw_i(trip), .blank_cnt_i(bcnt),
        .adapt_en_i(adapt), .step_mag_i(step), .trip_o(trip_o), .blank_o(blank_o));

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem = 0; held = 0; texp = 0;
        end else begin
            bit go, masked, nt, nh;
            int len;
            go = on_s || (fast_s && auto_d);
            masked = (rem > 0) || go;
            nt = !masked && trip && !held;
            nh = !masked && trip;
            if (go) begin
                len = int'(bcnt);
                if (adapt && (int'(step) * 10 < FS * 3)) len = len / 2;
                rem = len;
            end else if (rem > 0) begin
                rem = rem - 1;
            end
            texp = nt;
            held = nh;
        end
    end

    task automatic check(input string r, input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", r, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check(req, blank_o, (rem > 0), "blank_o");
        check(req, trip_o, texp, "trip_o");
        if (trip_o) pulses++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_on();
        on_s = 1; cyc(1); on_s = 0;
    endtask

    task automatic pulse_fast();
        fast_s = 1; cyc(1); fast_s = 0;
    endtask

    task automatic expect_pulses(input string r, input int n);
        checks++;
        if (pulses != n) begin
            fails++;
            $display("FAIL %s pulse count actual=%0d expected=%0d", r, pulses, n);
        end
        pulses = 0;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        // R9 reset state
        cyc(3);
        check("R9", blank_o, 1'b0, "blank in reset");
        check("R9", trip_o, 1'b0, "trip in reset");
        rst_n = 1;
        cyc(2);
        pulses = 0;

        // R1 / R2: full window, trip held high throughout
        req = "R1"; bcnt = 10; step = 200; adapt = 1; trip = 1;
        pulse_on();
        req = "R2"; cyc(14);
        expect_pulses("R2", 1);
        trip = 0; cyc(2);

        // R8: re-trip on a new rising edge, one pulse each
        req = "R8"; trip = 1; cyc(3); trip = 0; cyc(2); trip = 1; cyc(3); trip = 0; cyc(2);
        expect_pulses("R8", 2);

        // R4: boundary of the 30% threshold
        req = "R4"; step = 76; bcnt = 11; pulse_on(); cyc(8);
        step = 77; pulse_on(); cyc(13);
        adapt = 0; step = 10; pulse_on(); cyc(13);

        // R3: fast decay restart under automatic decay
        req = "R3"; adapt = 0; bcnt = 6; auto_d = 1; pulse_fast(); cyc(3);
        trip = 1; pulse_fast(); cyc(9);
        expect_pulses("R3", 1);
        trip = 0; cyc(2);

        // R5: fast decay strobe ignored when not automatic
        req = "R5"; auto_d = 0; pulse_fast(); cyc(2);
        trip = 1; cyc(3);
        expect_pulses("R5", 1);
        trip = 0; cyc(2);

        // R6: changing inputs mid window
        req = "R6"; adapt = 1; step = 200; bcnt = 12; pulse_on(); cyc(3);
        step = 5; bcnt = 2; adapt = 0; cyc(12);

        // R7: restart inside a running window
        req = "R7"; bcnt = 9; pulse_on(); cyc(5); trip = 1; pulse_on(); cyc(12);
        expect_pulses("R7", 1);
        trip = 0; cyc(2);

        // R10: zero length
        req = "R10"; bcnt = 0; trip = 1; pulse_on(); cyc(3);
        expect_pulses("R10", 1);
        trip = 0; cyc(3);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule